// File: doc/BRIEF.md
# Receive transaction ordering arbiter

This block sits between the receive side of a transaction layer and the application logic. Incoming packet descriptors, each 136 bits wide, are sorted into three class queues: posted, non-posted and completion. The block then offers one descriptor at a time to the application through a request/acknowledge handshake. Descriptors inside one class always leave in arrival order.

The application has three ways to close an offer. It can acknowledge the descriptor and take it, or abort it and discard it. Both of these pop the descriptor and release its receive credit. The third way is a retry, which leaves the descriptor at the head of its queue so that it is offered again later.

A mask input lets the application refuse non-posted traffic for a while. While the mask is high, posted and completion descriptors move ahead of it. When the mask drops, the non-posted descriptors that were waiting at that moment are served before the other classes.

Top module: `rx_order_arbiter`

## Requirements
- R1: The class of a descriptor is taken from bits 129:128, the two low bits of its type byte 135:128. The codes are 00 posted, 01 non-posted and 10 completion. Code 11 is handled as posted.
- R2: Each class queue holds DEPTH descriptors, 4 by default. `in_ready_o` is low exactly when the queue for the class of `in_desc_i` is full. A descriptor is stored only when `in_valid_i` and `in_ready_o` are both high.
- R3: Within one class, descriptors are offered in the order they arrived.
- R4: While `req_o` is high and no ack, abort, retry or mask is asserted, `req_o` stays high and `desc_o` does not change.
- R5: An acknowledge or abort pops the offered descriptor. `req_o` is low in the next cycle, and arbitration for the next offer happens at the edge that follows.
- R6: A retry closes the offer without popping the descriptor and without any credit pulse. The same descriptor stays at the head of its queue.
- R7: One cycle after an acknowledge or abort, `credit_vld_o` pulses for exactly one cycle. `credit_cls_o` carries the popped class (00 posted, 01 non-posted, 10 completion), and the pulse returns one header credit.
- R8: When no mask-release priority is pending, a new offer goes to the first non-empty queue in this order: posted, completion, non-posted.
- R9: From the cycle after `mask_i` is first seen high, and for as long as it stays high, no non-posted descriptor is offered. A non-posted offer that is open in the first masked cycle is withdrawn at the end of that cycle, unless it is closed in that same cycle.
- R10: At the edge where `mask_i` is seen falling, the number of non-posted descriptors waiting is captured. Non-posted offers then have top priority until that many non-posted descriptors have been popped.
- R11: Acknowledge, abort and retry have no effect while `req_o` is low. When more than one is asserted, acknowledge wins over abort, and abort wins over retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Incoming descriptor valid |
| in_desc_i | input | 136 | Incoming descriptor; type byte in 135:128 |
| in_ready_o | output | 1 | Target class queue has room |
| req_o | output | 1 | Descriptor offered to the application |
| desc_o | output | 136 | Offered descriptor |
| ack_i | input | 1 | Application takes the offered descriptor |
| abort_i | input | 1 | Application discards the offered descriptor |
| retry_i | input | 1 | Application asks for a later re-offer |
| mask_i | input | 1 | Block non-posted offers |
| credit_vld_o | output | 1 | One-cycle credit release pulse |
| credit_cls_o | output | 2 | Class of the released credit |

## Verification
Two events can fall in the same cycle: the mask falling, and an acknowledge of a posted or completion descriptor. When that happens, the pop, the credit pulse and the capture of the non-posted backlog all take effect at one edge. The directed sequence builds this case on purpose. It holds a non-posted backlog behind the mask, acknowledges posted descriptors while the mask is still high, and then drops the mask while posted descriptors are still queued. Long random runs toggle the mask and the handshake inputs independently, so the same case also occurs by chance. A bench model checks every cycle that the next offer is non-posted, that the credit class belongs to the packet just popped, and that the posted descriptors follow only once the captured backlog has drained.

// File: rtl/rxo_pkg.sv
package rxo_pkg;
  localparam int DESC_W   = 136;
  localparam int NCLS     = 3;
  localparam int TYPE_LSB = 128;

  typedef enum logic [1:0] {
    CLS_P   = 2'b00,
    CLS_NP  = 2'b01,
    CLS_CPL = 2'b10
  } cls_e;

  function automatic cls_e desc_cls(input logic [DESC_W-1:0] d);
    case (d[TYPE_LSB+1 -: 2])
      2'b01:   return CLS_NP;
      2'b10:   return CLS_CPL;
      default: return CLS_P;
    endcase
  endfunction
endpackage

// File: rtl/rxo_fifo.sv
module rxo_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q < CW'(DEPTH) || pop_i));
  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0);
endmodule

// File: rtl/rxo_sel.sv
module rxo_sel import rxo_pkg::*; #(
  parameter int CW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCLS-1:0] nonempty_i,
  input  logic            mask_i,
  input  logic [CW-1:0]   np_cnt_i,
  input  logic            np_pop_i,
  output logic            win_vld_o,
  output cls_e            win_cls_o
);
  logic          mask_q;
  logic [CW-1:0] boost_q;
  logic          np_ok;

  // mask falling edge loads the backlog that must drain first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= 1'b0;
      boost_q <= '0;
    end else begin
      mask_q <= mask_i;
      if (mask_q && !mask_i)              boost_q <= np_cnt_i;
      else if (np_pop_i && boost_q != '0) boost_q <= boost_q - 1'b1;
    end
  end

  assign np_ok = nonempty_i[CLS_NP] && !mask_i;

  always_comb begin
    win_vld_o = 1'b1;
    win_cls_o = CLS_P;
    if (np_ok && boost_q != '0)   win_cls_o = CLS_NP;
    else if (nonempty_i[CLS_P])   win_cls_o = CLS_P;
    else if (nonempty_i[CLS_CPL]) win_cls_o = CLS_CPL;
    else if (np_ok)               win_cls_o = CLS_NP;
    else                          win_vld_o = 1'b0;
  end

  assert_boost_bounded_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boost_q != '0 && !(mask_q && !mask_i)) |-> boost_q <= np_cnt_i);
endmodule

// File: rtl/rxo_credit.sv
module rxo_credit import rxo_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rel_i,
  input  cls_e       cls_i,
  output logic       vld_o,
  output logic [1:0] cls_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      cls_o <= 2'b00;
    end else begin
      vld_o <= rel_i;
      if (rel_i) cls_o <= cls_i;
    end
  end
endmodule

// File: rtl/rx_order_arbiter.sv
module rx_order_arbiter import rxo_pkg::*; #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DESC_W-1:0] in_desc_i,
  output logic              in_ready_o,
  output logic              req_o,
  output logic [DESC_W-1:0] desc_o,
  input  logic              ack_i,
  input  logic              abort_i,
  input  logic              retry_i,
  input  logic              mask_i,
  output logic              credit_vld_o,
  output logic [1:0]        credit_cls_o
);
  cls_e              in_cls;
  logic [NCLS-1:0]   nonempty, full_v, push_v, pop_v;
  logic [DESC_W-1:0] head_a [NCLS];
  logic [CW-1:0]     cnt_a  [NCLS];
  logic              offer_vld_q;
  cls_e              offer_cls_q;
  logic              win_vld;
  cls_e              win_cls;
  logic              rel_w, rtry_w, wdraw_w;

  assign in_cls = desc_cls(in_desc_i);

  always_comb begin
    case (in_cls)
      CLS_NP:  in_ready_o = !full_v[1];
      CLS_CPL: in_ready_o = !full_v[2];
      default: in_ready_o = !full_v[0];
    endcase
  end

  // close of an offer: ack beats abort beats retry
  assign rel_w   = offer_vld_q && (ack_i || abort_i);
  assign rtry_w  = offer_vld_q && !ack_i && !abort_i && retry_i;
  assign wdraw_w = offer_vld_q && !rel_w && !rtry_w && mask_i && offer_cls_q == CLS_NP;

  for (genvar g = 0; g < NCLS; g++) begin : g_q
    assign nonempty[g] = cnt_a[g] != '0;
    assign full_v[g]   = cnt_a[g] == CW'(DEPTH);
    assign push_v[g]   = in_valid_i && !full_v[g] && in_cls == cls_e'(2'(g));
    assign pop_v[g]    = rel_w && offer_cls_q == cls_e'(2'(g));

    rxo_fifo #(.W(DESC_W), .DEPTH(DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push_v[g]),
      .data_i  (in_desc_i),
      .pop_i   (pop_v[g]),
      .head_o  (head_a[g]),
      .count_o (cnt_a[g])
    );
  end

  rxo_sel #(.CW(CW)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .nonempty_i (nonempty),
    .mask_i     (mask_i),
    .np_cnt_i   (cnt_a[1]),
    .np_pop_i   (pop_v[1]),
    .win_vld_o  (win_vld),
    .win_cls_o  (win_cls)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offer_vld_q <= 1'b0;
      offer_cls_q <= CLS_P;
    end else if (offer_vld_q) begin
      if (rel_w || rtry_w || wdraw_w) offer_vld_q <= 1'b0;
    end else if (win_vld) begin
      offer_vld_q <= 1'b1;
      offer_cls_q <= win_cls;
    end
  end

  assign req_o = offer_vld_q;

  always_comb begin
    case (offer_cls_q)
      CLS_NP:  desc_o = head_a[1];
      CLS_CPL: desc_o = head_a[2];
      default: desc_o = head_a[0];
    endcase
  end

  rxo_credit u_credit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rel_i  (rel_w),
    .cls_i  (offer_cls_q),
    .vld_o  (credit_vld_o),
    .cls_o  (credit_cls_o)
  );

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i && !abort_i && !retry_i && !mask_i) |=> (req_o && $stable(desc_o)));
  assert_drop_after_pop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && (ack_i || abort_i)) |=> !req_o);
  assert_retry_no_credit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && retry_i && !ack_i && !abort_i) |=> !credit_vld_o);
  assert_credit_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && (ack_i || abort_i)) |=> (credit_vld_o && credit_cls_o == $past(offer_cls_q)));
  assert_credit_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    credit_vld_o |-> $past(req_o && (ack_i || abort_i)));
  assert_np_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mask_i) |-> !(req_o && offer_cls_q == CLS_NP));
  assert_idle_inert_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |=> !credit_vld_o);
endmodule

// File: tb/rx_order_arbiter_bench.sv
`timescale 1ns/1ps
module rx_order_arbiter_bench;
  localparam int DEPTH = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic [135:0] in_desc_i = '0;
  logic         in_ready_o, req_o;
  logic [135:0] desc_o;
  logic         ack_i = 1'b0, abort_i = 1'b0, retry_i = 1'b0, mask_i = 1'b0;
  logic         credit_vld_o;
  logic [1:0]   credit_cls_o;

  always #2.5 clk_i = ~clk_i;

  rx_order_arbiter #(.DEPTH(DEPTH)) u_rx_order_arbiter (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_desc_i(in_desc_i),
    .in_ready_o(in_ready_o), .req_o(req_o), .desc_o(desc_o), .ack_i(ack_i),
    .abort_i(abort_i), .retry_i(retry_i), .mask_i(mask_i),
    .credit_vld_o(credit_vld_o), .credit_cls_o(credit_cls_o));

  int    n_tests = 0, n_fail = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // reference model state
  logic [135:0] mq [3][DEPTH];
  int mc [3];
  bit m_vld, m_cr, m_mask;
  int m_cls, m_cr_cls, m_boost;

  task automatic chk(input bit ok, input string what, input logic [135:0] got, input logic [135:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // R1: class code in bits 129:128, 11 folds into posted
  function automatic int cls_of(input logic [135:0] d);
    return (d[129:128] == 2'b11) ? 0 : int'(d[129:128]);
  endfunction

  function automatic logic [135:0] mkd(input int c);
    logic [135:0] d;
    d = {$urandom, $urandom, $urandom, $urandom, 8'($urandom)};
    d[129:128] = 2'(c);
    return d;
  endfunction

  function automatic int pick(input bit m);
    if (m_boost > 0 && mc[1] > 0 && !m) return 1;
    if (mc[0] > 0) return 0;
    if (mc[2] > 0) return 2;
    if (mc[1] > 0 && !m) return 1;
    return -1;
  endfunction

  task automatic step(input bit v, input logic [135:0] d, input bit a, input bit ab,
                      input bit rt, input bit m);
    int c, w, pop_c, n_cls, n_boost;
    bit push, rel, rte, n_vld;
    in_valid_i = v; in_desc_i = d; ack_i = a; abort_i = ab; retry_i = rt; mask_i = m;
    #1;
    c = cls_of(d);
    chk(in_ready_o === (mc[c] < DEPTH), "R1 R2 in_ready_o", 136'(in_ready_o), 136'(mc[c] < DEPTH));
    push  = v && mc[c] < DEPTH;
    rel   = m_vld && (a || ab);
    rte   = m_vld && !a && !ab && rt;
    pop_c = rel ? m_cls : -1;
    n_cls = m_cls;
    if (m_vld) n_vld = !(rel || rte || (m_cls == 1 && m));
    else begin
      w = pick(m);
      n_vld = (w >= 0);
      if (w >= 0) n_cls = w;
    end
    if (m_mask && !m)                 n_boost = mc[1];
    else if (pop_c == 1 && m_boost > 0) n_boost = m_boost - 1;
    else                              n_boost = m_boost;
    @(posedge clk_i);
    if (pop_c >= 0) begin
      for (int i = 0; i < DEPTH - 1; i++) mq[pop_c][i] = mq[pop_c][i+1];
      mc[pop_c]--;
    end
    if (push) begin mq[c][mc[c]] = d; mc[c]++; end
    m_cr = rel; if (rel) m_cr_cls = m_cls;
    m_vld = n_vld; m_cls = n_cls; m_boost = n_boost; m_mask = m;
    @(negedge clk_i);
    chk(req_o === m_vld, "R5 req_o", 136'(req_o), 136'(m_vld));
    if (m_vld) chk(desc_o === mq[m_cls][0], "R3 R8 desc_o", desc_o, mq[m_cls][0]);
    chk(credit_vld_o === m_cr, "R7 credit_vld_o", 136'(credit_vld_o), 136'(m_cr));
    if (m_cr) chk(credit_cls_o === 2'(m_cr_cls), "R7 credit_cls_o", 136'(credit_cls_o), 136'(m_cr_cls));
  endtask

  task automatic idle(input int n, input bit a, input bit m);
    for (int i = 0; i < n; i++) step(1'b0, '0, a, 1'b0, 1'b0, m);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL R5 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    for (int k = 0; k < 3; k++) mc[k] = 0;
    m_vld = 0; m_cr = 0; m_mask = 0; m_cls = 0; m_cr_cls = 0; m_boost = 0;
    repeat (3) @(negedge clk_i);
    tag = "R7 reset";
    chk(req_o === 1'b0, "R5 reset req_o", 136'(req_o), 136'(0));
    chk(credit_vld_o === 1'b0, "R7 reset credit_vld_o", 136'(credit_vld_o), 136'(0));
    chk(in_ready_o === 1'b1, "R2 reset in_ready_o", 136'(in_ready_o), 136'(1));
    rst_ni = 1'b1;
    @(negedge clk_i);

    // fill posted through code 11 until full
    tag = "R1 R2";
    for (int i = 0; i < 6; i++) step(1'b1, mkd(3), 1'b0, 1'b0, 1'b0, 1'b0);
    // mixed classes, then drain with ack held high
    tag = "R8 R3";
    for (int i = 0; i < 2; i++) step(1'b1, mkd(1), 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 2; i++) step(1'b1, mkd(2), 1'b0, 1'b0, 1'b0, 1'b0);
    tag = "R11 ack while idle";
    idle(20, 1'b1, 1'b0);

    // retry keeps head, posted overtakes retried non-posted
    tag = "R6";
    step(1'b1, mkd(1), 1'b0, 1'b0, 1'b0, 1'b0);
    idle(2, 1'b0, 1'b0);
    step(1'b1, mkd(0), 1'b0, 1'b0, 1'b1, 1'b0);
    idle(2, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    idle(1, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b1, 1'b1, 1'b0);
    idle(4, 1'b1, 1'b0);

    // mask withdraws non-posted, posted goes first, backlog wins on release
    tag = "R9 R10";
    for (int i = 0; i < 2; i++) step(1'b1, mkd(1), 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b1, mkd(0), 1'b0, 1'b0, 1'b0, 1'b1);
    idle(2, 1'b1, 1'b1);
    step(1'b1, mkd(1), 1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, mkd(1), 1'b0, 1'b0, 1'b0, 1'b0);
    idle(16, 1'b1, 1'b0);

    // random traffic
    tag = "R4 random";
    begin
      bit mk;
      mk = 1'b0;
      for (int i = 0; i < 6000; i++) begin
        if ($urandom_range(19) == 0) mk = !mk;
        step($urandom_range(9) < 6, mkd($urandom_range(3)), $urandom_range(9) < 3,
             $urandom_range(9) == 0, $urandom_range(9) < 2, mk);
      end
    end
    tag = "R4 drain";
    idle(40, 1'b1, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule